// File: doc/BRIEF.md
# Card Socket Window Decoder

This block sits between a host memory bus and one removable-card socket. The socket owns a 256 MB region of host address space. The block splits that region into four 64 MB quarters. Three of them map to the card's I/O space, attribute memory and common memory. The fourth is an unused hole. Each host access to a mapped quarter goes to the card with a space code and an offset measured from the start of its window. The access is forwarded only while a card is in the socket. When the socket is empty, reads return zero and writes are dropped.

The block also tracks whether the socket is occupied, using insert and eject request pulses. A successful insert raises a card-detect interrupt. A successful eject lowers that interrupt and the forwarded card interrupt. A request that cannot be honoured gives a one-cycle error pulse and changes nothing. The card's own interrupt line reaches the host only while an interrupt sink is enabled.

Top module: `card_socket_decoder`

## Requirements
- R1: The window is chosen by host_addr[27:26]. 2'b00 gives card_space 0 (I/O), 2'b10 gives card_space 1 (attribute) and 2'b11 gives card_space 2 (common). card_offset equals host_addr[25:0]. While the socket is occupied, card_req equals host_req in the same cycle.
- R2: When host_addr[27:26] is 2'b01 (the hole), card_req stays low and host_rdata is zero. dec_err is high in the cycle after each such request and low in the cycle after that.
- R3: While the socket is not occupied, card_req stays low and host_rdata is zero for every address and direction.
- R4: For a forwarded access, card_we follows host_we and card_wdata follows host_wdata. On a forwarded read, host_rdata equals card_rdata in the same cycle. On a forwarded write, host_rdata is zero.
- R5: An insert request on an empty socket sets occupied and cd_irq from the next cycle on.
- R6: An insert request on an occupied socket pulses cmd_err for one cycle. occupied and cd_irq keep their values.
- R7: An eject request on an empty socket pulses cmd_err for one cycle, and the socket stays empty.
- R8: An eject request on an occupied socket clears occupied, cd_irq and host_irq in the next cycle, even while card_irq is still high.
- R9: host_irq is high in a cycle exactly when, at the previous clock edge, the socket was occupied both before and after the edge and irq_sink_en and card_irq were both high.
- R10: When insert_req and eject_req are high together, only the insert is acted on. On an occupied socket this gives a cmd_err pulse and the card stays in.
- R11: A synchronous active-high reset clears occupied, cd_irq, host_irq, cmd_err and dec_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access strobe, one access per cycle |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | 28 | Offset within the socket region |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data returned to the host |
| dec_err | output | 1 | One-cycle pulse after an access to the hole |
| card_req | output | 1 | Access strobe towards the card |
| card_we | output | 1 | Write strobe towards the card |
| card_space | output | 2 | 0 I/O, 1 attribute, 2 common, 3 none |
| card_offset | output | 26 | Offset within the selected window |
| card_wdata | output | 32 | Write data towards the card |
| card_rdata | input | 32 | Read data from the card |
| card_irq | input | 1 | Interrupt line from the card |
| irq_sink_en | input | 1 | Enables forwarding of the card interrupt |
| insert_req | input | 1 | Card insertion request |
| eject_req | input | 1 | Card removal request |
| cmd_err | output | 1 | One-cycle pulse on a rejected insert or eject |
| occupied | output | 1 | A card is present in the socket |
| cd_irq | output | 1 | Card-detect interrupt |
| host_irq | output | 1 | Card interrupt forwarded to the host |

## Verification
The hardest case to reach is an eject while the card interrupt is still being forwarded. The bench first inserts a card, enables the sink and holds card_irq high until host_irq is set. It then ejects the card without lowering card_irq, and checks that host_irq and cd_irq both drop in the next cycle. Simultaneous insert and eject requests are also driven onto an occupied socket, to show that the eject half is ignored. Address sweeps over all four quarters, at the edge and middle offsets, are run once with the socket empty and once with it occupied.

// File: rtl/card_sock_pkg.sv
package card_sock_pkg;
    typedef enum logic [1:0] {
        SP_IO     = 2'd0,
        SP_ATTR   = 2'd1,
        SP_COMMON = 2'd2,
        SP_NONE   = 2'd3
    } space_e;

    typedef struct packed {
        logic present;
        logic cd_irq;
        logic host_irq;
        logic cmd_err;
    } sock_state_t;

    typedef struct packed {
        logic dec_err;
    } dec_state_t;
endpackage

// File: rtl/sock_window_decode.sv
module sock_window_decode
    import card_sock_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int WIN_W  = 26
) (
    input  logic [ADDR_W-1:0] addr,
    output space_e            space,
    output logic [WIN_W-1:0]  offset,
    output logic              hole
);
    localparam int SEL_W = ADDR_W - WIN_W;

    logic [SEL_W-1:0] sel;

    initial begin
        if (SEL_W != 2) $display("sock_window_decode: region must hold four windows");
    end

    assign sel    = addr[ADDR_W-1:WIN_W];
    assign offset = addr[WIN_W-1:0];

    always_comb begin
        space = SP_NONE;
        hole  = 1'b0;
        case (sel)
            2'd0:    space = SP_IO;
            2'd2:    space = SP_ATTR;
            2'd3:    space = SP_COMMON;
            default: hole  = 1'b1;
        endcase
    end
endmodule

// File: rtl/sock_access_gate.sv
module sock_access_gate
    import card_sock_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              host_req,
    input  logic              host_we,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              hole,
    input  logic              present,
    input  logic [DATA_W-1:0] card_rdata,
    output logic              card_req,
    output logic              card_we,
    output logic [DATA_W-1:0] card_wdata,
    output logic [DATA_W-1:0] host_rdata
);
    always_comb begin
        card_req   = host_req && present && !hole;
        card_we    = host_we;
        card_wdata = host_wdata;
        host_rdata = (card_req && !host_we) ? card_rdata : '0;
    end

    // R3: an empty socket never reaches the card
    assert_empty_gated_R3: assert property (@(posedge card_req) present);
endmodule

// File: rtl/sock_state.sv
module sock_state
    import card_sock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic insert_req,
    input  logic eject_req,
    input  logic card_irq,
    input  logic irq_sink_en,
    output logic present,
    output logic cd_irq,
    output logic host_irq,
    output logic cmd_err
);
    sock_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.cmd_err = 1'b0;
        if (insert_req) begin
            if (st_q.present) begin
                st_d.cmd_err = 1'b1;
            end else begin
                st_d.present = 1'b1;
                st_d.cd_irq  = 1'b1;
            end
        end else if (eject_req) begin
            if (!st_q.present) begin
                st_d.cmd_err = 1'b1;
            end else begin
                st_d.present = 1'b0;
                st_d.cd_irq  = 1'b0;
            end
        end
        st_d.host_irq = st_d.present && st_q.present && irq_sink_en && card_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign present  = st_q.present;
    assign cd_irq   = st_q.cd_irq;
    assign host_irq = st_q.host_irq;
    assign cmd_err  = st_q.cmd_err;

    assert_insert_sets_R5: assert property (@(posedge clk) disable iff (rst)
        (insert_req && !present) |=> (present && cd_irq && !cmd_err));
    assert_reject_insert_R6: assert property (@(posedge clk) disable iff (rst)
        (insert_req && present) |=> (cmd_err && present && $stable(cd_irq)));
    assert_reject_eject_R7: assert property (@(posedge clk) disable iff (rst)
        (!insert_req && eject_req && !present) |=> (cmd_err && !present));
    assert_eject_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (!insert_req && eject_req && present) |=> (!present && !cd_irq && !host_irq));
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        host_irq |-> ($past(irq_sink_en) && $past(card_irq)));
endmodule

// File: rtl/card_socket_decoder.sv
module card_socket_decoder
    import card_sock_pkg::*;
#(
    parameter int ADDR_W = 28,
    parameter int WIN_W  = 26,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              dec_err,
    output logic              card_req,
    output logic              card_we,
    output logic [1:0]        card_space,
    output logic [WIN_W-1:0]  card_offset,
    output logic [DATA_W-1:0] card_wdata,
    input  logic [DATA_W-1:0] card_rdata,
    input  logic              card_irq,
    input  logic              irq_sink_en,
    input  logic              insert_req,
    input  logic              eject_req,
    output logic              cmd_err,
    output logic              occupied,
    output logic              cd_irq,
    output logic              host_irq
);
    space_e     space;
    logic       hole;
    logic       present;
    dec_state_t dec_d, dec_q;

    sock_window_decode #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) i_decode (
        .addr   (host_addr),
        .space  (space),
        .offset (card_offset),
        .hole   (hole)
    );

    sock_access_gate #(.DATA_W(DATA_W)) i_gate (
        .host_req   (host_req),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .hole       (hole),
        .present    (present),
        .card_rdata (card_rdata),
        .card_req   (card_req),
        .card_we    (card_we),
        .card_wdata (card_wdata),
        .host_rdata (host_rdata)
    );

    sock_state i_state (
        .clk         (clk),
        .rst         (rst),
        .insert_req  (insert_req),
        .eject_req   (eject_req),
        .card_irq    (card_irq),
        .irq_sink_en (irq_sink_en),
        .present     (present),
        .cd_irq      (cd_irq),
        .host_irq    (host_irq),
        .cmd_err     (cmd_err)
    );

    assign card_space = space;
    assign occupied   = present;

    always_comb begin
        dec_d         = dec_q;
        dec_d.dec_err = host_req && hole;
    end

    always_ff @(posedge clk) begin
        if (rst) dec_q <= '0;
        else     dec_q <= dec_d;
    end

    assign dec_err = dec_q.dec_err;

    assert_hole_blocked_R2: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_addr[ADDR_W-1:WIN_W] == 2'b01) |-> (!card_req && host_rdata == '0));
    assert_hole_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (host_req && host_addr[ADDR_W-1:WIN_W] == 2'b01) |=> dec_err);
    assert_forward_R1: assert property (@(posedge clk) disable iff (rst)
        (occupied && host_req && host_addr[ADDR_W-1:WIN_W] != 2'b01) |-> card_req);
    assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
        !occupied |-> (!card_req && host_rdata == '0));
endmodule

// File: tb/test_card_socket_decoder.sv
module test_card_socket_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        host_req, host_we;
    logic [27:0] host_addr;
    logic [31:0] host_wdata, host_rdata, card_wdata, card_rdata;
    logic        dec_err, card_req, card_we;
    logic [1:0]  card_space;
    logic [25:0] card_offset;
    logic        card_irq, irq_sink_en, insert_req, eject_req;
    logic        cmd_err, occupied, cd_irq, host_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign card_rdata = {4'hA, card_space, card_offset};

    card_socket_decoder i_card_socket_decoder (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(bit we, logic [27:0] addr, logic [31:0] wd, bit pres);
        logic [1:0] w;
        logic [1:0] exp_sp;
        bit fwd;
        w      = addr[27:26];
        exp_sp = (w == 2'd0) ? 2'd0 : (w == 2'd2) ? 2'd1 : (w == 2'd3) ? 2'd2 : 2'd3;
        fwd    = pres && (w != 2'd1);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
        #1;
        check(pres ? "R1 card_req" : "R3 card_req", {31'd0, card_req}, {31'd0, fwd});
        check("R1 space", {30'd0, card_space}, {30'd0, exp_sp});
        check("R1 offset", {6'd0, card_offset}, {6'd0, addr[25:0]});
        if (!pres)
            check("R3 rdata", host_rdata, 32'd0);
        else if (w == 2'd1)
            check("R2 rdata", host_rdata, 32'd0);
        else if (we) begin
            check("R4 wdata", card_wdata, wd);
            check("R4 we", {31'd0, card_we}, 32'd1);
            check("R4 write rdata", host_rdata, 32'd0);
        end else
            check("R4 rdata", host_rdata, {4'hA, exp_sp, addr[25:0]});
        @(negedge clk);
        host_req = 1'b0;
        check("R2 dec_err", {31'd0, dec_err}, {31'd0, (w == 2'd1)});
        @(negedge clk);
        check("R2 dec_err drop", {31'd0, dec_err}, 32'd0);
    endtask

    task automatic sweep(bit pres);
        logic [25:0] offs [4];
        offs[0] = 26'd0; offs[1] = 26'd1; offs[2] = 26'h1555555; offs[3] = 26'h3FFFFFF;
        for (int w = 0; w < 4; w++)
            for (int k = 0; k < 4; k++)
                for (int d = 0; d < 2; d++)
                    access(d[0], {w[1:0], offs[k]}, 32'h5A00_0000 + 32'(w * 16 + k), pres);
    endtask

    task automatic cmd(bit ins, bit ej);
        @(negedge clk);
        insert_req = ins; eject_req = ej;
        @(negedge clk);
        insert_req = 1'b0; eject_req = 1'b0;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        card_irq = 1'b0; irq_sink_en = 1'b0; insert_req = 1'b0; eject_req = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 occupied", {31'd0, occupied}, 32'd0);
        check("R11 cd_irq", {31'd0, cd_irq}, 32'd0);
        check("R11 host_irq", {31'd0, host_irq}, 32'd0);
        check("R11 errs", {30'd0, cmd_err, dec_err}, 32'd0);
        rst = 1'b0;

        sweep(1'b0);

        cmd(1'b0, 1'b1);
        check("R7 cmd_err", {31'd0, cmd_err}, 32'd1);
        check("R7 occupied", {31'd0, occupied}, 32'd0);

        cmd(1'b1, 1'b0);
        check("R5 occupied", {31'd0, occupied}, 32'd1);
        check("R5 cd_irq", {31'd0, cd_irq}, 32'd1);
        check("R5 cmd_err", {31'd0, cmd_err}, 32'd0);

        cmd(1'b1, 1'b0);
        check("R6 cmd_err", {31'd0, cmd_err}, 32'd1);
        check("R6 occupied", {31'd0, occupied}, 32'd1);
        check("R6 cd_irq", {31'd0, cd_irq}, 32'd1);
        @(negedge clk);
        check("R6 cmd_err pulse", {31'd0, cmd_err}, 32'd0);

        sweep(1'b1);

        for (int e = 0; e < 2; e++)
            for (int q = 0; q < 2; q++) begin
                @(negedge clk);
                irq_sink_en = e[0]; card_irq = q[0];
                @(negedge clk);
                check("R9 host_irq", {31'd0, host_irq}, {31'd0, e[0] & q[0]});
            end

        cmd(1'b1, 1'b1);
        check("R10 cmd_err", {31'd0, cmd_err}, 32'd1);
        check("R10 occupied", {31'd0, occupied}, 32'd1);
        check("R10 host_irq kept", {31'd0, host_irq}, 32'd1);

        cmd(1'b0, 1'b1);
        check("R8 occupied", {31'd0, occupied}, 32'd0);
        check("R8 cd_irq", {31'd0, cd_irq}, 32'd0);
        check("R8 host_irq", {31'd0, host_irq}, 32'd0);
        @(negedge clk);
        check("R9 empty host_irq", {31'd0, host_irq}, 32'd0);

        cmd(1'b1, 1'b0);
        @(negedge clk);
        check("R9 after insert", {31'd0, host_irq}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 occupied after", {31'd0, occupied}, 32'd0);
        check("R11 irqs after", {30'd0, cd_irq, host_irq}, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule